// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correct

This block is the 8-bit arithmetic and logic unit of a small accumulator machine. It owns the accumulator together with a carry flag and a half-carry flag. On each clock edge where an operation is offered, it combines the accumulator with an 8-bit operand according to an operation code. It then writes the new accumulator and flag values back into its own registers. Instruction fetch, decode, memory access and operand addressing stay with the surrounding core. That core presents the operand already fetched, and it raises a side flag to say whether the previous arithmetic step was a subtraction.

Arithmetic uses a split adder, so the carry out of bit 3 is available as the half carry. A separate decimal-correct operation uses that half carry and the carry to turn the binary result of a preceding add-with-carry or subtract-with-carry into packed BCD. Logic operations, clear, increment, decrement and nibble swap touch only the accumulator. Set-carry and reset-carry drive both flags together.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator, carry and half carry are all cleared to 0 at that edge.
- R2: Op code 0 (plain add) loads acc_q with (acc_q + operand) mod 256 and leaves carry_q and half_q unchanged.
- R3: Op code 1 (add with carry) loads acc_q with (acc_q + operand + carry_q) mod 256. It sets carry_q to the carry out of bit 7 and half_q to the carry out of bit 3.
- R4: Op code 2 (subtract with carry, carry set meaning no borrow) loads acc_q with (acc_q + ~operand + carry_q) mod 256 and updates carry_q and half_q as in R3.
- R5: Op codes 3, 4 and 5 load acc_q with the bitwise AND, OR and XOR of acc_q and operand, and leave both flags unchanged.
- R6: Op codes 6, 7 and 8 load acc_q with 0, acc_q + 1 and acc_q - 1 (mod 256), and leave both flags unchanged.
- R7: Op code 9 (decimal correct) with dc_after_sub low adds 0x06 when half_q is 1 or the low nibble exceeds 9. It adds 0x60 and sets carry_q when carry_q is 1 or acc_q exceeds 0x99; otherwise carry_q is kept. half_q is unchanged.
- R8: Op code 9 with dc_after_sub high subtracts 0x06 when half_q is 0 and 0x60 when carry_q is 0; both flags are unchanged.
- R9: Op code 10 (rotate right through carry) moves carry_q into bit 7, shifts each accumulator bit down one place and moves the old bit 0 into carry_q; half_q is unchanged.
- R10: Op code 11 exchanges acc_q bits 7..4 with bits 3..0 and leaves both flags unchanged.
- R11: Op code 12 sets both carry_q and half_q to 1, and op code 13 clears both; the accumulator is unchanged.
- R12: With op_valid low, or with op codes 14 and 15, the accumulator and both flags keep their values.
- R13: A result is visible on acc_q, carry_q and half_q right after the clock edge that samples op_valid high, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 4 | Operation selector, codes per R2 to R12 |
| operand | input | 8 | Memory or immediate operand |
| dc_after_sub | input | 1 | High when the preceding arithmetic step was a subtraction |
| acc_q | output | 8 | Accumulator register |
| carry_q | output | 1 | Carry flag (no-borrow flag for subtraction) |
| half_q | output | 1 | Half-carry flag, carry out of bit 3 |

## Verification
The arithmetic operations are driven with operands chosen so that nibble carries and byte carries occur independently. One case carries only out of bit 3, and another only out of bit 7. This shows whether the half carry really comes from the low nibble. Subtraction runs once with and once without a borrow, which tells a correct inverted-operand path apart from a plain two's-complement one. Decimal correct is tried after adds that need a low fix only, a fix in both nibbles with carry out, and a fix forced by the half carry alone. After subtracts, it is tried with and without borrow, which separates the four adjustment paths. Rotate runs with the carry both set and clear. Idle cycles and reserved codes are placed after states with nonzero flags, so any unwanted write would show.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths and the operation code set of the accumulator ALU.
// Assumes an 8-bit data path split into two 4-bit nibbles for the half carry.
package acc_alu_pkg;

    localparam int ALU_W  = 8;
    localparam int NIB_W  = ALU_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUBC = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CLR  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_DCOR = 4'd9,
        OP_RRC  = 4'd10,
        OP_SWAP = 4'd11,
        OP_SETC = 4'd12,
        OP_RSTC = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: split adder for add, add-with-carry and subtract-with-carry.
// Computes the low nibble first so the carry out of bit 3 is available as
// the half carry. Subtraction inverts the operand; carry-in 1 means no borrow.
// Purely combinational; the caller decides which flags to keep.
module acc_alu_addsub #(
    parameter int W   = acc_alu_pkg::ALU_W,
    parameter int NIB = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         use_cin_i,
    input  logic         invert_b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hout_o
);

    localparam int HI_W = W - NIB;

    logic [W-1:0]    b_eff;
    logic            ci;
    logic [NIB:0]    lo_sum;
    logic [HI_W:0]   hi_sum;

    // Select the operand polarity and whether the carry participates.
    always_comb begin
        b_eff = invert_b_i ? ~b_i : b_i;
        ci    = use_cin_i & cin_i;
    end

    // Two-stage ripple: low nibble then high part with the nibble carry.
    always_comb begin
        lo_sum = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, ci};
        hi_sum = {1'b0, a_i[W-1:NIB]} + {1'b0, b_eff[W-1:NIB]} + {{HI_W{1'b0}}, lo_sum[NIB]};
        sum_o  = {hi_sum[HI_W-1:0], lo_sum[NIB-1:0]};
        cout_o = hi_sum[HI_W];
        hout_o = lo_sum[NIB];
    end

endmodule

// File: rtl/acc_alu_decadj.sv
// Module: decimal correction of the accumulator after a binary add or
// subtract of packed BCD values. Assumes an 8-bit, two-digit accumulator and
// that the flags are the ones left by the preceding arithmetic step.
// Combinational; only the carry may be changed, and only after an add.
module acc_alu_decadj #(
    parameter int W   = acc_alu_pkg::ALU_W,
    parameter int NIB = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         h_i,
    input  logic         after_sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);

    localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
    localparam logic [NIB-1:0] DIGIT_FIX = NIB'(6);
    localparam logic [W-1:0]   BYTE_MAX  = {DIGIT_MAX, DIGIT_MAX};

    logic          lo_fix;
    logic          hi_fix;
    logic [W-1:0]  adj;

    // Decide which digits need fixing for the kind of step that came before.
    always_comb begin
        if (after_sub_i) begin
            lo_fix = ~h_i;
            hi_fix = ~c_i;
        end else begin
            lo_fix = h_i | (a_i[NIB-1:0] > DIGIT_MAX);
            hi_fix = c_i | (a_i > BYTE_MAX);
        end
        adj = {(hi_fix ? DIGIT_FIX : {NIB{1'b0}}), (lo_fix ? DIGIT_FIX : {NIB{1'b0}})};
    end

    // Apply the adjustment and derive the carry.
    always_comb begin
        if (after_sub_i) begin
            res_o = a_i - adj;
            c_o   = c_i;
        end else begin
            res_o = a_i + adj;
            c_o   = c_i | hi_fix;
        end
    end

endmodule

// File: rtl/acc_alu_shift.sv
// Module: rotate right through carry and nibble swap of the accumulator.
// Combinational; the swap output ignores the carry, the rotate output
// returns the bit shifted out as the new carry.
module acc_alu_shift #(
    parameter int W   = acc_alu_pkg::ALU_W,
    parameter int NIB = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    output logic [W-1:0] rot_o,
    output logic         rot_c_o,
    output logic [W-1:0] swap_o
);

    // Rotate: carry enters at the top, bit 0 leaves as the carry.
    always_comb begin
        rot_o   = {c_i, a_i[W-1:1]};
        rot_c_o = a_i[0];
    end

    // Swap: each nibble moves to the other half, built bit by bit.
    for (genvar i = 0; i < NIB; i++) begin : g_swap
        assign swap_o[i]       = a_i[i + NIB];
        assign swap_o[i + NIB] = a_i[i];
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Holds the accumulator, carry and half carry,
// and on each edge with op_valid high applies the operation in op_code.
// Assumes the operand is already fetched and that dc_after_sub tells the
// decimal-correct step whether the previous arithmetic was a subtraction.
// Reserved op codes and idle cycles hold all state. Synchronous active-low reset.
module acc_alu #(
    parameter int W = acc_alu_pkg::ALU_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [acc_alu_pkg::OP_W-1:0] op_code,
    input  logic [W-1:0]                operand,
    input  logic                        dc_after_sub,
    output logic [W-1:0]                acc_q,
    output logic                        carry_q,
    output logic                        half_q
);

    import acc_alu_pkg::*;

    localparam int NIB = W / 2;

    alu_op_e      op;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_h;
    logic [W-1:0] dc_res;
    logic         dc_c;
    logic [W-1:0] rot_res;
    logic         rot_c;
    logic [W-1:0] swap_res;
    logic [W-1:0] acc_d;
    logic         carry_d;
    logic         half_d;

    assign op = alu_op_e'(op_code);

    acc_alu_addsub #(.W(W), .NIB(NIB)) u_addsub (
        .a_i        (acc_q),
        .b_i        (operand),
        .cin_i      (carry_q),
        .use_cin_i  (op != OP_ADD),
        .invert_b_i (op == OP_SUBC),
        .sum_o      (as_sum),
        .cout_o     (as_c),
        .hout_o     (as_h)
    );

    acc_alu_decadj #(.W(W), .NIB(NIB)) u_decadj (
        .a_i         (acc_q),
        .c_i         (carry_q),
        .h_i         (half_q),
        .after_sub_i (dc_after_sub),
        .res_o       (dc_res),
        .c_o         (dc_c)
    );

    acc_alu_shift #(.W(W), .NIB(NIB)) u_shift (
        .a_i     (acc_q),
        .c_i     (carry_q),
        .rot_o   (rot_res),
        .rot_c_o (rot_c),
        .swap_o  (swap_res)
    );

    // Select the next accumulator and flag values for the offered operation.
    always_comb begin
        acc_d   = acc_q;
        carry_d = carry_q;
        half_d  = half_q;
        if (op_valid) begin
            unique case (op)
                OP_ADD:  acc_d = as_sum;
                OP_ADC, OP_SUBC: begin
                    acc_d   = as_sum;
                    carry_d = as_c;
                    half_d  = as_h;
                end
                OP_AND:  acc_d = acc_q & operand;
                OP_OR:   acc_d = acc_q | operand;
                OP_XOR:  acc_d = acc_q ^ operand;
                OP_CLR:  acc_d = '0;
                OP_INC:  acc_d = acc_q + W'(1);
                OP_DEC:  acc_d = acc_q - W'(1);
                OP_DCOR: begin
                    acc_d   = dc_res;
                    carry_d = dc_c;
                end
                OP_RRC: begin
                    acc_d   = rot_res;
                    carry_d = rot_c;
                end
                OP_SWAP: acc_d = swap_res;
                OP_SETC: begin
                    carry_d = 1'b1;
                    half_d  = 1'b1;
                end
                OP_RSTC: begin
                    carry_d = 1'b0;
                    half_d  = 1'b0;
                end
                OP_RSV0, OP_RSV1: ;
                default: ;
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            carry_q <= carry_d;
            half_q  <= half_d;
        end
    end

endmodule

// Module: property checker for acc_alu, bound to every instance.
module acc_alu_chk #(
    parameter int W = acc_alu_pkg::ALU_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         op_valid,
    input logic [acc_alu_pkg::OP_W-1:0] op_code,
    input logic [W-1:0]                 operand,
    input logic                         dc_after_sub,
    input logic [W-1:0]                 acc_q,
    input logic                         carry_q,
    input logic                         half_q
);

    import acc_alu_pkg::*;

    localparam int NIB = W / 2;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && !carry_q && !half_q)); // R1

    AST_ADD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD) |=> ($stable(carry_q) && $stable(half_q))); // R2

    AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> ($stable(carry_q) && $stable(half_q))); // R5

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_INC) |=> (acc_q == $past(acc_q) + W'(1))); // R6

    AST_DCOR_SUB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_DCOR && dc_after_sub)
        |=> ($stable(carry_q) && $stable(half_q))); // R8

    AST_RRC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RRC)
        |=> (carry_q == $past(acc_q[0]) && acc_q[W-1] == $past(carry_q) && $stable(half_q))); // R9

    AST_SWAP_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SWAP)
        |=> (acc_q == {$past(acc_q[NIB-1:0]), $past(acc_q[W-1:NIB])})); // R10

    AST_SETC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SETC) |=> (carry_q && half_q && $stable(acc_q))); // R11

    AST_RSTC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RSTC) |=> (!carry_q && !half_q && $stable(acc_q))); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == OP_RSV0 || op_code == OP_RSV1)
        |=> ($stable(acc_q) && $stable(carry_q) && $stable(half_q))); // R12

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .operand      (operand),
    .dc_after_sub (dc_after_sub),
    .acc_q        (acc_q),
    .carry_q      (carry_q),
    .half_q       (half_q)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

    typedef struct {
        logic [7:0] acc;
        logic       c;
        logic       h;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] operand = 8'd0;
    logic       dc_after_sub = 1'b0;
    logic [7:0] acc_q;
    logic       carry_q;
    logic       half_q;

    int         checks = 0;
    int         failures = 0;
    logic       tb_item = 1'b0;
    logic       done = 1'b0;
    exp_t       sb_q[$];

    // Reference state kept by the bench.
    logic [7:0] m_acc = 8'd0;
    logic       m_c = 1'b0;
    logic       m_h = 1'b0;

    always #2 clk = ~clk;

    acc_alu uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .operand      (operand),
        .dc_after_sub (dc_after_sub),
        .acc_q        (acc_q),
        .carry_q      (carry_q),
        .half_q       (half_q)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (acc_q !== e.acc || carry_q !== e.c || half_q !== e.h) begin
            failures++;
            $display("FAIL %s acc=%h exp=%h c=%b exp=%b hc=%b exp=%b",
                     e.tag, acc_q, e.acc, carry_q, e.c, half_q, e.h);
        end
    endtask

    // Reference model of one step, written from the requirements.
    task automatic model(input logic v, input logic [3:0] op, input logic [7:0] b, input logic sub);
        int s;
        int t;
        if (!v) return;
        case (op)
            4'd0: m_acc = m_acc + b;
            4'd1, 4'd2: begin
                int bb;
                bb = (op == 4'd2) ? ((~b) & 8'hFF) : b;
                s = m_acc + bb + m_c;
                m_h = ((m_acc & 15) + (bb & 15) + m_c) > 15;
                m_c = s > 255;
                m_acc = s[7:0];
            end
            4'd3: m_acc = m_acc & b;
            4'd4: m_acc = m_acc | b;
            4'd5: m_acc = m_acc ^ b;
            4'd6: m_acc = 8'd0;
            4'd7: m_acc = m_acc + 8'd1;
            4'd8: m_acc = m_acc - 8'd1;
            4'd9: begin
                t = m_acc;
                if (sub) begin
                    if (!m_h) t = t - 6;
                    if (!m_c) t = t - 'h60;
                end else begin
                    if (m_h || (m_acc & 15) > 9) t = t + 6;
                    if (m_c || m_acc > 8'h99) begin
                        t = t + 'h60;
                        m_c = 1'b1;
                    end
                end
                m_acc = t[7:0];
            end
            4'd10: begin
                s = m_acc[0];
                m_acc = {m_c, m_acc[7:1]};
                m_c = s[0];
            end
            4'd11: m_acc = {m_acc[3:0], m_acc[7:4]};
            4'd12: begin m_c = 1'b1; m_h = 1'b1; end
            4'd13: begin m_c = 1'b0; m_h = 1'b0; end
            default: ;
        endcase
    endtask

    // Driver: offers one cycle of stimulus and queues the expected state.
    task automatic step(input logic v, input logic [3:0] op, input logic [7:0] b,
                        input logic sub, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid     = v;
        op_code      = op;
        operand      = b;
        dc_after_sub = sub;
        model(v, op, b, sub);
        e.acc = m_acc;
        e.c   = m_c;
        e.h   = m_h;
        e.tag = tag;
        sb_q.push_back(e);
        tb_item = 1'b1;
    endtask

    task automatic quiet();
        @(negedge clk);
        op_valid = 1'b0;
        tb_item  = 1'b0;
    endtask

    // Monitor: after each edge that consumed a driven item, compare at the negedge.
    initial begin
        forever begin
            @(posedge clk);
            if (tb_item) begin
                @(negedge clk);
                if (sb_q.size() > 0) compare(sb_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r.acc = 8'd0; r.c = 1'b0; r.h = 1'b0; r.tag = "R1 reset";
        compare(r);
        rst_n = 1'b1;

        step(1, 4'd12, 8'h00, 0, "R11 setc");
        step(1, 4'd0,  8'h10, 0, "R2 add keeps flags");
        step(1, 4'd1,  8'h0F, 0, "R3 adc half carry only");
        step(1, 4'd1,  8'hF0, 0, "R3 adc carry only");
        step(1, 4'd13, 8'h00, 0, "R11 rstc");
        step(1, 4'd2,  8'h01, 0, "R4 subc with borrow in");
        step(1, 4'd2,  8'h20, 0, "R4 subc borrow out");
        step(1, 4'd3,  8'h3C, 0, "R5 and");
        step(1, 4'd4,  8'h81, 0, "R5 or");
        step(1, 4'd5,  8'hFF, 0, "R5 xor");
        step(1, 4'd6,  8'h55, 0, "R6 clr");
        step(1, 4'd8,  8'h00, 0, "R6 dec wrap");
        step(1, 4'd7,  8'h00, 0, "R13 inc wrap latency");
        // Decimal correct after add: low fix only.
        step(1, 4'd13, 8'h00, 0, "R11 rstc");
        step(1, 4'd0,  8'h15, 0, "R2 add");
        step(1, 4'd1,  8'h27, 0, "R3 adc bcd");
        step(1, 4'd9,  8'h00, 0, "R7 dcor low fix");
        // Both digits fixed with carry out.
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd13, 8'h00, 0, "R11 rstc");
        step(1, 4'd0,  8'h99, 0, "R2 add");
        step(1, 4'd1,  8'h01, 0, "R3 adc bcd");
        step(1, 4'd9,  8'h00, 0, "R7 dcor both fix carry");
        // Half carry alone forces the low fix.
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd13, 8'h00, 0, "R11 rstc");
        step(1, 4'd0,  8'h08, 0, "R2 add");
        step(1, 4'd1,  8'h09, 0, "R3 adc half");
        step(1, 4'd9,  8'h00, 0, "R7 dcor half carry");
        // Decimal correct after subtract, no borrow.
        step(1, 4'd12, 8'h00, 0, "R11 setc");
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd0,  8'h42, 0, "R2 add");
        step(1, 4'd2,  8'h15, 0, "R4 subc bcd");
        step(1, 4'd9,  8'h00, 1, "R8 dcor sub low");
        // After subtract with borrow.
        step(1, 4'd12, 8'h00, 0, "R11 setc");
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd0,  8'h15, 0, "R2 add");
        step(1, 4'd2,  8'h42, 0, "R4 subc bcd borrow");
        step(1, 4'd9,  8'h00, 1, "R8 dcor sub high");
        // Rotate with carry set then clear.
        step(1, 4'd12, 8'h00, 0, "R11 setc");
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd0,  8'h81, 0, "R2 add");
        step(1, 4'd10, 8'h00, 0, "R9 rrc carry in");
        step(1, 4'd13, 8'h00, 0, "R11 rstc");
        step(1, 4'd10, 8'h00, 0, "R9 rrc carry clear");
        // Swap.
        step(1, 4'd12, 8'h00, 0, "R11 setc");
        step(1, 4'd6,  8'h00, 0, "R6 clr");
        step(1, 4'd0,  8'hA5, 0, "R2 add");
        step(1, 4'd11, 8'h00, 0, "R10 swap");
        // Idle and reserved codes hold state.
        step(0, 4'd6,  8'hFF, 0, "R12 idle clr");
        step(0, 4'd13, 8'hFF, 0, "R12 idle rstc");
        step(1, 4'd14, 8'hFF, 0, "R12 reserved 14");
        step(1, 4'd15, 8'hFF, 0, "R12 reserved 15");
        quiet();
        @(negedge clk);

        // Reset in mid-run clears nonzero state.
        rst_n = 1'b0;
        @(negedge clk);
        r.acc = 8'd0; r.c = 1'b0; r.h = 1'b0; r.tag = "R1 mid-run reset";
        compare(r);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule